// File: doc/BRIEF.md
# Partition-Pairing Memory Request Scheduler

This block schedules commands for a nonvolatile memory whose banks are divided into partitions. The partitions of a bank work almost independently, but they share one set of sense amplifiers and write drivers. Requests enter a small queue. Each entry holds a read/write flag, a bank, a partition, a request ID and a pass-over age. For each command slot the scheduler chooses one request, or two requests to different partitions of the same bank, and emits the matching single or combined command on a valid/ready command port.

A combined read-plus-write is preceded by a decouple command. Any command that contains a read is followed by a transfer command, which moves the read data off the shared sense path. A static power budget decides which kinds of pair may be issued. An age threshold forces a request that has been passed over too often to issue alone, ahead of any pairing.

Top module: `pair_sched`

## Requirements
- R1: After reset no command is offered (`cmd_valid`=0), `in_ready`=1 and the queue is empty.
- R2: A request is accepted on `in_valid && in_ready` into the lowest free slot. `in_ready` is 0 exactly when all DEPTH slots are occupied.
- R3: A new selection is taken only in a cycle where the scheduler is idle and `cmd_ready` is 1. An offered command holds all of its fields stable until it is accepted. An entry leaves the queue only when its command is accepted.
- R4: Two requests are paired only if both target the same bank and different partitions, and they are either two reads or one read plus one write. Two writes are never paired.
- R5: When no request is aged, a legal pair is preferred over a single request. Pairs are searched by lowest first index, then lowest second index. With no legal pair, the lowest-indexed valid entry issues alone.
- R6: A pair issues only if its cost fits within BUDGET. A read-read pair costs 2*RD_COST and a read-write pair costs RD_COST+WR_COST. With the defaults (2, 5, 7) both kinds fit. With BUDGET=6 a read-write pair is split into two singles.
- R7: A read-write pair is issued as opcode 4 (decouple, same bank, slot fields zero), then opcode 3. Slot 0 carries the read's partition and ID and slot 1 carries the write's.
- R8: Every accepted command that contains a read (opcodes 0, 2, 3) is followed at once by opcode 5 (transfer) to the same bank, with slot fields zero. A plain write (opcode 1) is not followed by a transfer.
- R9: Each valid entry's age rises by one, saturating at AGE_LIMIT, on every accepted main command that does not serve it. An entry whose age has reached AGE_LIMIT issues alone, before any pairing, with the lowest index winning ties.
- R10: Opcodes are 0 read, 1 write, 2 read-read and 3 read-write. For single commands slot 1 is zero. For a read-read pair slot 0 is the lower queue index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue has a free slot |
| in_is_wr | input | 1 | 1 = write, 0 = read |
| in_bank | input | BANK_W | Target bank |
| in_part | input | PART_W | Target partition |
| in_id | input | ID_W | Request ID |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted / selection enable |
| cmd_op | output | 3 | Opcode (0..5) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_part0 | output | PART_W | Slot 0 partition |
| cmd_id0 | output | ID_W | Slot 0 request ID |
| cmd_part1 | output | PART_W | Slot 1 partition |
| cmd_id1 | output | ID_W | Slot 1 request ID |

## Verification
Several properties are checked on every cycle: command fields stay stable while stalled, a decouple is always followed by a read-write pair to the same bank, every read-bearing command is followed by a transfer, paired slots never share a partition, read-write pairs appear only when the budget allows them, ages stay within their cap, and occupancy rises by one on an accepted request. The choice of which requests issue and in what order can only be shown by the bench's scenarios. These include pair preference, refusal of same-partition, cross-bank and write-write pairing, budget splitting on a low-budget instance, age-forced singles, and back-pressure on a full queue.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int BANK_W = 2;
    localparam int PART_W = 2;
    localparam int ID_W   = 4;
    localparam int AGE_W  = 4;

    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_RDRD = 3'd2,
        OP_RDWR = 3'd3,
        OP_DEC  = 3'd4,
        OP_XFER = 3'd5
    } op_e;

    typedef struct packed {
        logic              vld;
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [PART_W-1:0] part;
        logic [ID_W-1:0]   id;
        logic [AGE_W-1:0]  age;
    } req_t;

    function automatic bit pair_fits(input logic a_wr, input logic b_wr,
                                     input int rd_cost, input int wr_cost, input int budget);
        if (a_wr && b_wr) return 1'b0;
        if (a_wr || b_wr) return (rd_cost + wr_cost) <= budget;
        return (2 * rd_cost) <= budget;
    endfunction
endpackage

// File: rtl/pps_queue.sv
module pps_queue
    import pps_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int AGE_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_is_wr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [PART_W-1:0] in_part,
    input  logic [ID_W-1:0]   in_id,
    output logic              in_ready,
    input  logic              serve,
    input  logic [DEPTH-1:0]  serve_mask,
    output req_t              q [DEPTH]
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AGE_W-1:0] AGE_CAP = AGE_W'(AGE_LIMIT);

    req_t             ent [DEPTH];
    logic [DEPTH-1:0] vld_vec;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i] = ent[i].vld;
            if (!ent[i].vld && !free_any) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign in_ready = free_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (serve && ent[i].vld) begin
                    if (serve_mask[i])
                        ent[i].vld <= 1'b0;
                    else if (ent[i].age < AGE_CAP)
                        ent[i].age <= ent[i].age + 1'b1;
                end
            end
            if (in_valid && free_any) begin
                ent[free_idx] <= '{vld: 1'b1, is_wr: in_is_wr, bank: in_bank,
                                   part: in_part, id: in_id, age: '0};
            end
        end
    end

    always_comb for (int i = 0; i < DEPTH; i++) q[i] = ent[i];

    // R2: an accepted request with no departure grows occupancy by one
    a_r2_enq_grows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !serve) |=> ($countones(vld_vec) == $countones($past(vld_vec)) + 1));

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_age_chk
            // R9: age saturates at the threshold
            a_r9_age_cap: assert property (@(posedge clk) disable iff (rst)
                ent[g].age <= AGE_CAP);
        end
    endgenerate
endmodule

// File: rtl/pps_pick.sv
module pps_pick
    import pps_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int AGE_LIMIT = 3,
    parameter int RD_COST   = 2,
    parameter int WR_COST   = 5,
    parameter int BUDGET    = 7
) (
    input  req_t                                  q [DEPTH],
    output logic                                  pick_vld,
    output logic                                  pick_dual,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] pick_a,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] pick_b
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AGE_W-1:0] AGE_CAP = AGE_W'(AGE_LIMIT);

    function automatic bit legal(input req_t x, input req_t y);
        return x.vld && y.vld && (x.bank == y.bank) && (x.part != y.part)
               && pair_fits(x.is_wr, y.is_wr, RD_COST, WR_COST, BUDGET);
    endfunction

    always_comb begin
        pick_vld  = 1'b0;
        pick_dual = 1'b0;
        pick_a    = '0;
        pick_b    = '0;
        // aged entries first, alone
        for (int i = 0; i < DEPTH; i++) begin
            if (!pick_vld && q[i].vld && q[i].age >= AGE_CAP) begin
                pick_vld = 1'b1;
                pick_a   = IDX_W'(i);
            end
        end
        // then the first legal pair, read placed in slot 0
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = i + 1; j < DEPTH; j++) begin
                if (!pick_vld && legal(q[i], q[j])) begin
                    pick_vld  = 1'b1;
                    pick_dual = 1'b1;
                    if (q[i].is_wr) begin
                        pick_a = IDX_W'(j);
                        pick_b = IDX_W'(i);
                    end else begin
                        pick_a = IDX_W'(i);
                        pick_b = IDX_W'(j);
                    end
                end
            end
        end
        // else lowest valid entry alone
        for (int i = 0; i < DEPTH; i++) begin
            if (!pick_vld && q[i].vld) begin
                pick_vld = 1'b1;
                pick_a   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pps_seq.sv
module pps_seq
    import pps_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int RD_COST = 2,
    parameter int WR_COST = 5,
    parameter int BUDGET  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              q [DEPTH],
    input  logic              pick_vld,
    input  logic              pick_dual,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] pick_a,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] pick_b,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [PART_W-1:0] cmd_part0,
    output logic [ID_W-1:0]   cmd_id0,
    output logic [PART_W-1:0] cmd_part1,
    output logic [ID_W-1:0]   cmd_id1,
    output logic              serve,
    output logic [DEPTH-1:0]  serve_mask
);
    typedef enum logic [1:0] {S_IDLE, S_DEC, S_MAIN, S_XFER} st_e;

    st_e               st;
    op_e               op_l;
    logic [BANK_W-1:0] bank_l;
    logic [PART_W-1:0] p0_l, p1_l;
    logic [ID_W-1:0]   i0_l, i1_l;
    logic              has_rd_l;
    logic [DEPTH-1:0]  mask_l;
    req_t              ra, rb;

    assign ra = q[pick_a];
    assign rb = q[pick_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            op_l     <= OP_RD;
            bank_l   <= '0;
            p0_l     <= '0;
            p1_l     <= '0;
            i0_l     <= '0;
            i1_l     <= '0;
            has_rd_l <= 1'b0;
            mask_l   <= '0;
        end else begin
            case (st)
                S_IDLE: if (cmd_ready && pick_vld) begin
                    op_l     <= pick_dual ? (rb.is_wr ? OP_RDWR : OP_RDRD)
                                          : (ra.is_wr ? OP_WR : OP_RD);
                    bank_l   <= ra.bank;
                    p0_l     <= ra.part;
                    i0_l     <= ra.id;
                    p1_l     <= pick_dual ? rb.part : '0;
                    i1_l     <= pick_dual ? rb.id : '0;
                    has_rd_l <= !ra.is_wr;
                    mask_l   <= (DEPTH'(1) << pick_a) | (pick_dual ? (DEPTH'(1) << pick_b) : '0);
                    st       <= (pick_dual && rb.is_wr) ? S_DEC : S_MAIN;
                end
                S_DEC:  if (cmd_ready) st <= S_MAIN;
                S_MAIN: if (cmd_ready) st <= has_rd_l ? S_XFER : S_IDLE;
                S_XFER: if (cmd_ready) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid = (st != S_IDLE);
        cmd_bank  = cmd_valid ? bank_l : '0;
        cmd_part0 = '0;
        cmd_id0   = '0;
        cmd_part1 = '0;
        cmd_id1   = '0;
        case (st)
            S_DEC:   cmd_op = OP_DEC;
            S_XFER:  cmd_op = OP_XFER;
            S_MAIN: begin
                cmd_op    = op_l;
                cmd_part0 = p0_l;
                cmd_id0   = i0_l;
                cmd_part1 = p1_l;
                cmd_id1   = i1_l;
            end
            default: cmd_op = OP_RD;
        endcase
    end

    assign serve      = (st == S_MAIN) && cmd_ready;
    assign serve_mask = mask_l;

    // R3: a stalled command keeps every field
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
            && $stable(cmd_part0) && $stable(cmd_id0) && $stable(cmd_part1) && $stable(cmd_id1)));
    // R7: decouple is followed by the read-write pair to the same bank
    a_r7_dec_then_pair: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == OP_DEC) |=>
            (cmd_valid && cmd_op == OP_RDWR && $stable(cmd_bank)));
    // R8: read-bearing commands are followed by a transfer to the same bank
    a_r8_xfer_follows: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_op == OP_RD || cmd_op == OP_RDRD || cmd_op == OP_RDWR)) |=>
            (cmd_valid && cmd_op == OP_XFER && $stable(cmd_bank)));
    // R4: paired slots never share a partition
    a_r4_distinct_parts: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_RDRD || cmd_op == OP_RDWR)) |-> (cmd_part0 != cmd_part1));
    // R6: read-write pairs only within budget
    a_r6_budget: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RDWR) |-> ((RD_COST + WR_COST) <= BUDGET));
endmodule

// File: rtl/pair_sched.sv
module pair_sched
    import pps_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int AGE_LIMIT = 3,
    parameter int RD_COST   = 2,
    parameter int WR_COST   = 5,
    parameter int BUDGET    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_is_wr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [PART_W-1:0] in_part,
    input  logic [ID_W-1:0]   in_id,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [PART_W-1:0] cmd_part0,
    output logic [ID_W-1:0]   cmd_id0,
    output logic [PART_W-1:0] cmd_part1,
    output logic [ID_W-1:0]   cmd_id1
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    req_t             q [DEPTH];
    logic             pick_vld, pick_dual, serve;
    logic [IDX_W-1:0] pick_a, pick_b;
    logic [DEPTH-1:0] serve_mask;
    op_e              op_int;

    pps_queue #(.DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) u_queue (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_wr(in_is_wr),
        .in_bank(in_bank), .in_part(in_part), .in_id(in_id), .in_ready(in_ready),
        .serve(serve), .serve_mask(serve_mask), .q(q)
    );

    pps_pick #(.DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT), .RD_COST(RD_COST),
               .WR_COST(WR_COST), .BUDGET(BUDGET)) u_pick (
        .q(q), .pick_vld(pick_vld), .pick_dual(pick_dual), .pick_a(pick_a), .pick_b(pick_b)
    );

    pps_seq #(.DEPTH(DEPTH), .RD_COST(RD_COST), .WR_COST(WR_COST), .BUDGET(BUDGET)) u_seq (
        .clk(clk), .rst(rst), .q(q), .pick_vld(pick_vld), .pick_dual(pick_dual),
        .pick_a(pick_a), .pick_b(pick_b), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
        .cmd_op(op_int), .cmd_bank(cmd_bank), .cmd_part0(cmd_part0), .cmd_id0(cmd_id0),
        .cmd_part1(cmd_part1), .cmd_id1(cmd_id1), .serve(serve), .serve_mask(serve_mask)
    );

    assign cmd_op = op_int;
endmodule

// File: tb/pair_sched_bench.sv
module pair_sched_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;  // 50 MHz

    logic       in_is_wr;
    logic [1:0] in_bank, in_part;
    logic [3:0] in_id;
    logic       in_valid [2];
    logic       in_ready [2];
    logic       cmd_ready [2];
    logic       cmd_valid [2];
    logic [2:0] cmd_op [2];
    logic [1:0] cmd_bank [2], cmd_p0 [2], cmd_p1 [2];
    logic [3:0] cmd_i0 [2], cmd_i1 [2];

    pair_sched #(.AGE_LIMIT(2)) u_pair_sched (
        .clk(clk), .rst(rst), .in_valid(in_valid[0]), .in_ready(in_ready[0]),
        .in_is_wr(in_is_wr), .in_bank(in_bank), .in_part(in_part), .in_id(in_id),
        .cmd_valid(cmd_valid[0]), .cmd_ready(cmd_ready[0]), .cmd_op(cmd_op[0]),
        .cmd_bank(cmd_bank[0]), .cmd_part0(cmd_p0[0]), .cmd_id0(cmd_i0[0]),
        .cmd_part1(cmd_p1[0]), .cmd_id1(cmd_i1[0]));

    pair_sched #(.AGE_LIMIT(2), .BUDGET(6)) u_pair_sched_lp (
        .clk(clk), .rst(rst), .in_valid(in_valid[1]), .in_ready(in_ready[1]),
        .in_is_wr(in_is_wr), .in_bank(in_bank), .in_part(in_part), .in_id(in_id),
        .cmd_valid(cmd_valid[1]), .cmd_ready(cmd_ready[1]), .cmd_op(cmd_op[1]),
        .cmd_bank(cmd_bank[1]), .cmd_part0(cmd_p0[1]), .cmd_id0(cmd_i0[1]),
        .cmd_part1(cmd_p1[1]), .cmd_id1(cmd_i1[1]));

    typedef struct {
        int    op, bank, p0, i0, p1, i1;
        string tag;
    } exp_t;

    exp_t exp_q0[$];
    exp_t exp_q1[$];
    int total = 0;
    int bad   = 0;
    int cycles = 0;

    task automatic check(input string tag, input int act, input int want, input string what);
        total++;
        if (act != want) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, want);
        end
    endtask

    task automatic push_req(input int u, input bit wr, input int bank, input int part, input int id);
        @(negedge clk);
        in_is_wr = wr; in_bank = 2'(bank); in_part = 2'(part); in_id = 4'(id);
        in_valid[u] = 1'b1;
        @(negedge clk);
        in_valid[u] = 1'b0;
    endtask

    task automatic expect_cmd(input int u, input int op, input int bank, input int p0,
                              input int i0, input int p1, input int i1, input string tag);
        exp_t e;
        e.op = op; e.bank = bank; e.p0 = p0; e.i0 = i0; e.p1 = p1; e.i1 = i1; e.tag = tag;
        if (u == 0) exp_q0.push_back(e); else exp_q1.push_back(e);
    endtask

    task automatic expect_xfer(input int u, input int bank, input string tag);
        expect_cmd(u, 5, bank, 0, 0, 0, 0, tag);
    endtask

    task automatic drain(input int u);
        int guard = 0;
        @(negedge clk);
        cmd_ready[u] = 1'b1;
        while (((u == 0) ? exp_q0.size() : exp_q1.size()) != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check("R3", guard < 2000 ? 1 : 0, 1, "drain completed");
        repeat (3) @(negedge clk);
        check("R3", int'(cmd_valid[u]), 0, "no extra command after drain");
        cmd_ready[u] = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compare accepted commands with the scoreboard
    for (genvar u = 0; u < 2; u++) begin : g_mon
        always @(negedge clk) begin
            if (!rst && cmd_valid[u] && cmd_ready[u]) begin
                exp_t e;
                if (((u == 0) ? exp_q0.size() : exp_q1.size()) == 0) begin
                    total++; bad++;
                    $display("FAIL R3 unexpected command: actual op=%0d expected none", cmd_op[u]);
                end else begin
                    e = (u == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                    check(e.tag, int'(cmd_op[u]), e.op, "opcode");
                    check(e.tag, int'(cmd_bank[u]), e.bank, "bank");
                    check(e.tag, int'(cmd_p0[u]), e.p0, "slot0 partition");
                    check(e.tag, int'(cmd_i0[u]), e.i0, "slot0 id");
                    check(e.tag, int'(cmd_p1[u]), e.p1, "slot1 partition");
                    check(e.tag, int'(cmd_i1[u]), e.i1, "slot1 id");
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        in_valid[0] = 0; in_valid[1] = 0; cmd_ready[0] = 0; cmd_ready[1] = 0;
        in_is_wr = 0; in_bank = 0; in_part = 0; in_id = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(cmd_valid[0]), 0, "cmd_valid after reset");
        check("R1", int'(in_ready[0]), 1, "in_ready after reset");

        // R4 R10: read-read pair, slot 0 lower index
        push_req(0, 0, 1, 0, 1);
        push_req(0, 0, 1, 2, 2);
        check("R3", int'(cmd_valid[0]), 0, "no issue while cmd_ready low");
        expect_cmd(0, 2, 1, 0, 1, 2, 2, "R4");
        expect_xfer(0, 1, "R8");
        drain(0);

        // R4: same partition is not paired
        push_req(0, 0, 0, 1, 3);
        push_req(0, 0, 0, 1, 4);
        expect_cmd(0, 0, 0, 1, 3, 0, 0, "R4");
        expect_xfer(0, 0, "R8");
        expect_cmd(0, 0, 0, 1, 4, 0, 0, "R4");
        expect_xfer(0, 0, "R8");
        drain(0);

        // R4 R8: two writes never paired, no transfer after writes
        push_req(0, 1, 2, 0, 5);
        push_req(0, 1, 2, 1, 6);
        expect_cmd(0, 1, 2, 0, 5, 0, 0, "R4");
        expect_cmd(0, 1, 2, 1, 6, 0, 0, "R8");
        drain(0);

        // R7: read-write pair, decouple first, read in slot 0
        push_req(0, 1, 3, 0, 7);
        push_req(0, 0, 3, 1, 8);
        expect_cmd(0, 4, 3, 0, 0, 0, 0, "R7");
        expect_cmd(0, 3, 3, 1, 8, 0, 7, "R7");
        expect_xfer(0, 3, "R8");
        drain(0);

        // R4: different banks not paired
        push_req(0, 0, 0, 0, 9);
        push_req(0, 0, 1, 1, 10);
        expect_cmd(0, 0, 0, 0, 9, 0, 0, "R4");
        expect_xfer(0, 0, "R8");
        expect_cmd(0, 0, 1, 1, 10, 0, 0, "R4");
        expect_xfer(0, 1, "R8");
        drain(0);

        // R5: pair preferred over lower-index single
        push_req(0, 0, 0, 0, 1);
        push_req(0, 1, 1, 0, 2);
        push_req(0, 0, 1, 1, 3);
        expect_cmd(0, 4, 1, 0, 0, 0, 0, "R5");
        expect_cmd(0, 3, 1, 1, 3, 0, 2, "R5");
        expect_xfer(0, 1, "R5");
        expect_cmd(0, 0, 0, 0, 1, 0, 0, "R5");
        expect_xfer(0, 0, "R5");
        drain(0);

        // R6: low budget splits read-write, still pairs reads
        push_req(1, 1, 2, 0, 11);
        push_req(1, 0, 2, 1, 12);
        push_req(1, 0, 3, 0, 13);
        push_req(1, 0, 3, 2, 14);
        expect_cmd(1, 2, 3, 0, 13, 2, 14, "R6");
        expect_xfer(1, 3, "R6");
        expect_cmd(1, 1, 2, 0, 11, 0, 0, "R6");
        expect_cmd(1, 0, 2, 1, 12, 0, 0, "R6");
        expect_xfer(1, 2, "R6");
        drain(1);

        // R9 R2: ageing forces singles; full queue blocks input
        push_req(0, 0, 0, 0, 0);
        push_req(0, 0, 1, 0, 1);
        push_req(0, 0, 1, 1, 2);
        push_req(0, 0, 1, 2, 3);
        push_req(0, 0, 1, 3, 4);
        push_req(0, 0, 2, 0, 5);
        push_req(0, 0, 2, 1, 6);
        check("R2", int'(in_ready[0]), 1, "in_ready with one slot free");
        push_req(0, 0, 3, 0, 7);
        check("R2", int'(in_ready[0]), 0, "in_ready when full");
        expect_cmd(0, 2, 1, 0, 1, 1, 2, "R9");
        expect_xfer(0, 1, "R9");
        expect_cmd(0, 2, 1, 2, 3, 3, 4, "R9");
        expect_xfer(0, 1, "R9");
        expect_cmd(0, 0, 0, 0, 0, 0, 0, "R9");
        expect_xfer(0, 0, "R9");
        expect_cmd(0, 0, 2, 0, 5, 0, 0, "R9");
        expect_xfer(0, 2, "R9");
        expect_cmd(0, 0, 2, 1, 6, 0, 0, "R9");
        expect_xfer(0, 2, "R9");
        expect_cmd(0, 0, 3, 0, 7, 0, 0, "R9");
        expect_xfer(0, 3, "R9");
        drain(0);
        check("R2", int'(in_ready[0]), 1, "in_ready after queue drained");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule